// File: doc/BRIEF.md
# DMA Bridge Event Interrupt Controller

This block gathers the ten completion and error events produced by a DMA bridge that moves data for a USB shared memory and two audio ports. Each event arrives as a one-cycle pulse and is latched in its own status flag. A matching enable flag decides whether the latched event may raise an interrupt. The events are grouped by kind onto three level interrupt lines: one for the USB address error, one for every all-done event, and one for every half-done event.

All enable and status flags live in a single 32-bit control word. Software reads it and writes it through a simple port: a write strobe with write data, and read data that always shows the current word. Writing 0 to a status flag acknowledges that event. Writing 0 to an enable flag masks it. An interrupt handler therefore reads the word, works out which events are pending, and writes back the acknowledgements.

Top module: `bridge_irq_ctrl`

## Requirements
- R1: After reset the control word reads 0x00000000 and all three interrupt lines are low.
- R2: A pulse on event n sets its status flag on the next clock edge, whether or not the event is enabled. Status flag positions: bit n for events 0 and 1, bit n+14 for events 2 to 9.
- R3: On a write, every enable flag takes its written value. Enable positions: bit n+8 for events 0 and 1, bit n+22 for events 2 to 9.
- R4: On a write, a status flag written 0 clears and a status flag written 1 keeps its value. Without a write and without a pulse, a status flag holds.
- R5: When an event pulse and a write of 0 to the same status flag fall in the same cycle, the flag ends up set.
- R6: Line 0 is high when event 1 (USB address error) is pending, meaning its status and enable flags are both 1.
- R7: Line 1 is high when any all-done event is pending: event 0 (USB transfer done) and events 2, 4, 6 and 8.
- R8: Line 2 is high when any half-done event is pending: events 3, 5, 7 and 9.
- R9: Each line is registered. It rises one edge after its first event becomes pending, and it falls one edge after its last pending event is cleared or masked.
- R10: Bits 15 to 10 and 7 to 2 always read 0, and writing 1 to them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_pulse | input | 10 | One-cycle event pulses, bit n for event n |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data for the control word |
| reg_rdata | output | 32 | Current control word |
| irq_line | output | 3 | Level interrupts: 0 address error, 1 all done, 2 half done |

## Verification
The assertions check the flag updates on every cycle and for every event: a set on each pulse, acknowledgement by a written 0, hold otherwise, the set winning over a clear, and enable loading. They also check that the unused bits stay zero and that each line equals, one cycle later, the OR of its pending events. The bench scenarios show the timing across several cycles. Only those scenarios show a line staying high in the cycle right after it was masked and dropping in the cycle after that, a burst of all ten events acknowledged at once, and long random mixes of writes and pulses compared against an independent model.

// File: rtl/bridge_irq_pkg.sv
package bridge_irq_pkg;
    localparam int NUM_EVT    = 10;
    localparam int NUM_USB    = 2;
    localparam int NUM_LINES  = 3;
    localparam int REG_W      = 32;
    localparam int USB_EN_OFS = 8;
    localparam int USB_ST_OFS = 0;
    localparam int AUD_EN_OFS = 22;
    localparam int AUD_ST_OFS = 14;

    typedef struct packed {
        logic [NUM_EVT-1:0] en;
        logic [NUM_EVT-1:0] st;
    } ctl_t;

    function automatic int en_pos(input int n);
        return (n < NUM_USB) ? n + USB_EN_OFS : n + AUD_EN_OFS;
    endfunction

    function automatic int st_pos(input int n);
        return (n < NUM_USB) ? n + USB_ST_OFS : n + AUD_ST_OFS;
    endfunction

    // 0: USB address error, 1: all-done kinds, 2: half-done kinds
    function automatic int line_of(input int n);
        if (n == 1) return 0;
        if (n == 0) return 1;
        return (n % 2 == 0) ? 1 : 2;
    endfunction
endpackage

// File: rtl/bridge_evt_cell.sv
module bridge_evt_cell (
    input  logic wr,
    input  logic wen_bit,
    input  logic wst_bit,
    input  logic pulse,
    input  logic en_q,
    input  logic st_q,
    output logic en_d,
    output logic st_d,
    output logic pending
);
    logic ack;

    always_comb begin
        ack     = wr & ~wst_bit;
        en_d    = wr ? wen_bit : en_q;
        // a pulse in the same cycle as an acknowledge keeps the flag set
        st_d    = pulse | (st_q & ~ack);
        pending = st_q & en_q;
    end
endmodule

// File: rtl/bridge_reg_map.sv
module bridge_reg_map
    import bridge_irq_pkg::*;
(
    input  ctl_t               ctl,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   rdata,
    output logic [NUM_EVT-1:0] wen,
    output logic [NUM_EVT-1:0] wst
);
    always_comb begin
        rdata = '0;
        for (int n = 0; n < NUM_EVT; n++) begin
            rdata[en_pos(n)] = ctl.en[n];
            rdata[st_pos(n)] = ctl.st[n];
            wen[n]           = wdata[en_pos(n)];
            wst[n]           = wdata[st_pos(n)];
        end
    end
endmodule

// File: rtl/bridge_irq_router.sv
module bridge_irq_router
    import bridge_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_EVT-1:0]   pending,
    output logic [NUM_LINES-1:0] irq_q
);
    logic [NUM_LINES-1:0] irq_d;

    always_comb begin
        irq_d = '0;
        for (int n = 0; n < NUM_EVT; n++) begin
            irq_d[line_of(n)] = irq_d[line_of(n)] | pending[n];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end
endmodule

// File: rtl/bridge_irq_ctrl.sv
module bridge_irq_ctrl
    import bridge_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_EVT-1:0]   evt_pulse,
    input  logic                 reg_wr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic [NUM_LINES-1:0] irq_line
);
    ctl_t               ctl_q, ctl_d;
    logic [NUM_EVT-1:0] wen, wst, nxt_en, nxt_st, pending;

    bridge_reg_map u_map (
        .ctl   (ctl_q),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .wen   (wen),
        .wst   (wst)
    );

    for (genvar n = 0; n < NUM_EVT; n++) begin : g_cell
        bridge_evt_cell u_cell (
            .wr      (reg_wr),
            .wen_bit (wen[n]),
            .wst_bit (wst[n]),
            .pulse   (evt_pulse[n]),
            .en_q    (ctl_q.en[n]),
            .st_q    (ctl_q.st[n]),
            .en_d    (nxt_en[n]),
            .st_d    (nxt_st[n]),
            .pending (pending[n])
        );
    end

    always_comb begin
        ctl_d.en = nxt_en;
        ctl_d.st = nxt_st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    bridge_irq_router u_router (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .irq_q   (irq_line)
    );
endmodule

// File: rtl/bridge_irq_ctrl_chk.sv
module bridge_irq_ctrl_chk
    import bridge_irq_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_EVT-1:0]   evt_pulse,
    input logic                 reg_wr,
    input logic [REG_W-1:0]     reg_wdata,
    input logic [REG_W-1:0]     reg_rdata,
    input logic [NUM_LINES-1:0] irq_line
);
    localparam logic [REG_W-1:0] UNUSED_MASK = 32'h0000_FCFC;

    for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
        localparam int EP = en_pos(k);
        localparam int SP = st_pos(k);

        AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
            evt_pulse[k] |=> reg_rdata[SP]); // R2
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_pulse[k] && reg_wr && !reg_wdata[SP]) |=> reg_rdata[SP]); // R5
        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && !reg_wdata[SP] && !evt_pulse[k]) |=> !reg_rdata[SP]); // R4
        AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            ((!reg_wr || reg_wdata[SP]) && reg_rdata[SP]) |=> reg_rdata[SP]); // R4
        AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            reg_wr |=> (reg_rdata[EP] == $past(reg_wdata[EP]))); // R3
        AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !reg_wr |=> $stable(reg_rdata[EP])); // R3
    end

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & UNUSED_MASK) == '0); // R10
    AST_LINE_ADDR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_line[0] == $past(reg_rdata[1] & reg_rdata[9])); // R6
    AST_LINE_ALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_line[1] == $past((reg_rdata[0] & reg_rdata[8]) | (reg_rdata[16] & reg_rdata[24]) |
                             (reg_rdata[18] & reg_rdata[26]) | (reg_rdata[20] & reg_rdata[28]) |
                             (reg_rdata[22] & reg_rdata[30]))); // R7
    AST_LINE_HALF_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_line[2] == $past((reg_rdata[17] & reg_rdata[25]) | (reg_rdata[19] & reg_rdata[27]) |
                             (reg_rdata[21] & reg_rdata[29]) | (reg_rdata[23] & reg_rdata[31]))); // R8
endmodule

bind bridge_irq_ctrl bridge_irq_ctrl_chk u_chk (.*);

// File: tb/bridge_irq_ctrl_tb.sv
module bridge_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  evt_pulse = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  irq_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [9:0] en_m = '0;
    logic [9:0] st_m = '0;
    logic [2:0] irq_m = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bridge_irq_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_pulse),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_line  (irq_line)
    );

    function automatic int b_en(input int n);
        return (n < 2) ? n + 8 : n + 22;
    endfunction

    function automatic int b_st(input int n);
        return (n < 2) ? n : n + 14;
    endfunction

    function automatic logic [31:0] b_word(input logic [9:0] en, input logic [9:0] st);
        logic [31:0] w = '0;
        for (int n = 0; n < 10; n++) begin
            w[b_en(n)] = en[n];
            w[b_st(n)] = st[n];
        end
        return w;
    endfunction

    function automatic logic [2:0] b_lines(input logic [9:0] en, input logic [9:0] st);
        logic [9:0] p = en & st;
        return {p[3] | p[5] | p[7] | p[9],
                p[0] | p[2] | p[4] | p[6] | p[8],
                p[1]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge, clock once, update the model, compare at the next falling edge
    task automatic step(input logic [9:0] pulse, input logic wr, input logic [31:0] wdata);
        evt_pulse = pulse;
        reg_wr    = wr;
        reg_wdata = wdata;
        @(posedge clk);
        irq_m = b_lines(en_m, st_m);
        for (int n = 0; n < 10; n++) begin
            if (wr) begin
                en_m[n] = wdata[b_en(n)];
                st_m[n] = st_m[n] & wdata[b_st(n)];
            end
            st_m[n] = st_m[n] | pulse[n];
        end
        @(negedge clk);
        evt_pulse = '0;
        reg_wr    = 1'b0;
        reg_wdata = '0;
        check("R4 control word", reg_rdata, b_word(en_m, st_m));
        check("R6 line 0", {31'd0, irq_line[0]}, {31'd0, irq_m[0]});
        check("R7 line 1", {31'd0, irq_line[1]}, {31'd0, irq_m[1]});
        check("R8 line 2", {31'd0, irq_line[2]}, {31'd0, irq_m[2]});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [9:0]  p;
        logic        w;
        logic [31:0] d;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset word", reg_rdata, 32'h0);
        check("R1 reset lines", {29'd0, irq_line}, 32'h0);

        // R10: all ones written, only enables land, status untouched
        step('0, 1'b1, 32'hFFFF_FFFF);
        check("R10 unused bits", reg_rdata, 32'hFF00_0300);
        step('0, 1'b1, 32'h0);

        // R2: pulses while masked still set status; lines stay low
        step(10'h3FF, 1'b0, 32'h0);
        check("R2 masked pulses latch", reg_rdata, 32'h00FF_0003);
        step('0, 1'b0, 32'h0);
        check("R2 masked lines low", {29'd0, irq_line}, 32'h0);

        // R5: acknowledge all with a pulse on event 5 in the same cycle
        step(10'h020, 1'b1, 32'h0);
        check("R5 set wins over clear", reg_rdata, 32'h0008_0000);

        // R3 and R9: enable event 5 and event 1, keep status
        step(10'h002, 1'b1, 32'h08FF_0203);
        check("R3 enables loaded", reg_rdata & 32'hFF00_0300, 32'h0800_0200);
        check("R9 line not yet raised", {29'd0, irq_line}, 32'h0);
        step('0, 1'b0, 32'h0);
        check("R9 lines raised one edge later", {29'd0, irq_line}, 32'h5);

        // R9: mask everything; lines hold for one edge then fall
        step('0, 1'b1, 32'h00FF_0003);
        check("R9 line held after mask", {29'd0, irq_line}, 32'h5);
        step('0, 1'b0, 32'h0);
        check("R9 line dropped", {29'd0, irq_line}, 32'h0);

        // R7: USB transfer done on the all-done line
        step(10'h001, 1'b1, 32'h0000_0100);
        step('0, 1'b0, 32'h0);
        check("R7 USB done on line 1", {29'd0, irq_line}, 32'h2);

        // R4: writing 1 to status keeps it, 0 clears it
        step('0, 1'b1, 32'h0000_0101);
        check("R4 keep on write of 1", reg_rdata, 32'h0000_0101);
        step('0, 1'b1, 32'h0000_0100);
        check("R4 clear on write of 0", reg_rdata, 32'h0000_0100);

        for (int i = 0; i < RAND_CYCLES; i++) begin
            p = 10'($urandom & $urandom & $urandom);
            w = (($urandom % 4) == 0);
            d = $urandom;
            step(p, w, d);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule